// File: doc/BRIEF.md
# Bus Error Status Capture Unit

This block keeps the fault record for an I/O bridge. It watches three classes of fault: uncorrectable memory ECC errors, correctable memory ECC errors and errors on the system bus. Each class has a 64-bit status word and a fault address register. An upstream checker reports each fault as a one-cycle event. The event carries a class code, a cause code, the faulting address, the transfer size as a power of two, the master ID, the doubleword offset, the ECC syndrome and a read flag.

The first fault in a class is the primary fault. It sets a primary cause bit and freezes its address and detail fields. Any later fault in the same class only sets a secondary cause bit, and this continues until software clears the primary bits. Software clears cause bits by writing ones to them over a simple register port. Each class drives an interrupt line that is high while a primary cause is pending and the class's enable is set.

Top module: `errcap_top`

## Requirements
- R1: After reset, every register reads zero and all three interrupt lines are low.
- R2: An event in a class with no primary bit set sets that class's primary bit and captures the address and detail fields. Class codes are 0 uncorrectable, 1 correctable, 2 bus. Cause code 0 sets bit 63, 1 sets bit 62 and 2 sets bit 61. The fields are size at bits 44:42 and master ID at bits 41:37. Class code 3 or cause code 3 records nothing.
- R3: An event in a class whose primary bit is already set sets only the secondary bit (cause 0 bit 60, 1 bit 59, 2 bit 58). The primary bits, the captured fields and the address stay as they were.
- R4: The ECC classes capture the doubleword offset at bits 47:45. Only the correctable class captures the syndrome at bits 55:48. The uncorrectable class reads zero there.
- R5: The bus class captures the read flag at bit 47 and reads zero at bits 46:45 and 55:48.
- R6: A write to a status register clears exactly the cause bits (63:58) written as one and leaves the fields. Writing back the value just read clears all pending causes.
- R7: When an event and a status write arrive in the same cycle, the write is applied first. If no primary bit remains, the event is recorded as primary with its own fields, even if the write cleared that bit.
- R8: The uncorrectable interrupt is high while a primary bit of that class is set and the ECC control register's bit 62 is 1. The correctable interrupt does the same with bit 61. The bus interrupt uses bit 8 of the bus control register.
- R9: While bit 63 of the ECC control register is 0, events in the two ECC classes are ignored. Bus-class events are always recorded.
- R10: The register select codes are: 0/1 uncorrectable status/address, 2/3 correctable status/address, 4/5 bus status/address, 6 ECC control and 7 bus control. The control registers read back only their enable bits. Address registers ignore writes. Status bits 57:56 always read zero.
- R11: An event changes only the registers of its own class.
- R12: The read port is combinational. An event or a write sampled at a clock edge is visible on the read data and the interrupt lines right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evtValid | input | 1 | Fault event strobe, one cycle per event |
| evtClass | input | 2 | Fault class code |
| evtCause | input | 2 | Cause code within the class |
| evtAddr | input | ADDR_W | Faulting address |
| evtSize | input | 3 | Log2 of transfer size |
| evtMid | input | 5 | Faulting master ID |
| evtDoff | input | 3 | Doubleword offset |
| evtSynd | input | 8 | ECC syndrome |
| evtRead | input | 1 | Faulting access was a read |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Register read data for regSel |
| irqUe | output | 1 | Uncorrectable-error interrupt |
| irqCe | output | 1 | Correctable-error interrupt |
| irqBus | output | 1 | Bus-error interrupt |

## Verification
Every state change is registered exactly once. An event or write driven at a falling edge therefore shows up on the read data and interrupt lines after the next rising edge. Reads are combinational, so the bench changes regSel and samples a moment later, well before the next rising edge. The same timing covers the interrupt checks after an enable write or a clear. The same-cycle event-and-clear case is driven as a single cycle, and the result is read straight after that edge.

// File: rtl/errcap_pkg.sv
package errcap_pkg;
  localparam int REG_W   = 64;
  localparam int NUM_CLS = 3;
  localparam int SEL_W   = 3;

  typedef enum logic [1:0] {
    CLS_UE  = 2'd0,
    CLS_CE  = 2'd1,
    CLS_BUS = 2'd2
  } cls_e;

  localparam logic [SEL_W-1:0] SEL_ECC_CTL = 3'd6;
  localparam logic [SEL_W-1:0] SEL_BUS_CTL = 3'd7;

  typedef struct packed {
    logic       capture;
    logic [2:0] setPrim;
    logic [2:0] setSec;
    logic [2:0] clrPrim;
    logic [2:0] clrSec;
  } cls_strobe_t;

  typedef struct packed {
    cls_strobe_t [NUM_CLS-1:0] cls;
    logic                      wrEcc;
    logic                      wrBus;
  } strobe_t;
endpackage

// File: rtl/errcap_ctrl.sv
module errcap_ctrl
  import errcap_pkg::*;
(
  input  logic                          evtValid,
  input  logic [1:0]                    evtClass,
  input  logic [1:0]                    evtCause,
  input  logic                          regWrEn,
  input  logic [SEL_W-1:0]              regSel,
  input  logic [5:0]                    wrCause,
  input  logic [NUM_CLS-1:0][2:0]       primNow,
  input  logic                          eccChkEn,
  output strobe_t                       strb
);
  logic       evtOk;
  logic [2:0] causeVec;

  always_comb begin
    evtOk = evtValid && (evtClass != 2'd3) && (evtCause != 2'd3) &&
            ((evtClass == CLS_BUS) || eccChkEn);
    causeVec = 3'b100 >> evtCause;
  end

  always_comb begin
    logic statWr;
    strb = '0;
    for (int c = 0; c < NUM_CLS; c++) begin
      statWr = regWrEn && (regSel == SEL_W'(2 * c));
      if (statWr) begin
        strb.cls[c].clrPrim = wrCause[5:3];
        strb.cls[c].clrSec  = wrCause[2:0];
      end
      if (evtOk && (evtClass == 2'(c))) begin
        // primary slot judged after this cycle's clear: event beats clear
        if ((primNow[c] & ~strb.cls[c].clrPrim) == 3'b000) begin
          strb.cls[c].capture = 1'b1;
          strb.cls[c].setPrim = causeVec;
        end else begin
          strb.cls[c].setSec = causeVec;
        end
      end
    end
    strb.wrEcc = regWrEn && (regSel == SEL_ECC_CTL);
    strb.wrBus = regWrEn && (regSel == SEL_BUS_CTL);
  end
endmodule

// File: rtl/errcap_dp.sv
module errcap_dp
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 64
)(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [ADDR_W-1:0]             evtAddr,
  input  logic [2:0]                    evtSize,
  input  logic [4:0]                    evtMid,
  input  logic [2:0]                    evtDoff,
  input  logic [7:0]                    evtSynd,
  input  logic                          evtRead,
  input  logic [2:0]                    wrEccBits,
  input  logic                          wrBusBit,
  input  logic [SEL_W-1:0]              regSel,
  output logic [REG_W-1:0]              regRdData,
  output logic [NUM_CLS-1:0][REG_W-1:0] statNow,
  output logic [NUM_CLS-1:0][ADDR_W-1:0] capAddr,
  output logic                          eccChkEn,
  output logic [NUM_CLS-1:0]            irqVec
);
  logic [2:0] eccCtlQ;
  logic       busEnQ;

  for (genvar g = 0; g < NUM_CLS; g++) begin : gCls
    cls_strobe_t       s;
    logic [2:0]        primQ, secQ, sizeQ;
    logic [4:0]        midQ;
    logic [ADDR_W-1:0] addrQ;
    logic [REG_W-1:0]  base, extra;

    assign s = strb.cls[g];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        primQ <= '0;
        secQ  <= '0;
        sizeQ <= '0;
        midQ  <= '0;
        addrQ <= '0;
      end else begin
        primQ <= (primQ & ~s.clrPrim) | s.setPrim;
        secQ  <= (secQ & ~s.clrSec) | s.setSec;
        if (s.capture) begin
          sizeQ <= evtSize;
          midQ  <= evtMid;
          addrQ <= evtAddr;
        end
      end
    end

    always_comb begin
      base = '0;
      base[63:61] = primQ;
      base[60:58] = secQ;
      base[44:42] = sizeQ;
      base[41:37] = midQ;
    end

    if (g == int'(CLS_BUS)) begin : gBus
      logic rdQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          rdQ <= 1'b0;
        else if (s.capture) rdQ <= evtRead;
      end
      always_comb begin
        extra = '0;
        extra[47] = rdQ;
      end
    end else begin : gEcc
      logic [2:0] doffQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)          doffQ <= '0;
        else if (s.capture) doffQ <= evtDoff;
      end
      if (g == int'(CLS_CE)) begin : gSynd
        logic [7:0] syndQ;
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN)          syndQ <= '0;
          else if (s.capture) syndQ <= evtSynd;
        end
        always_comb begin
          extra = '0;
          extra[47:45] = doffQ;
          extra[55:48] = syndQ;
        end
      end else begin : gNoSynd
        always_comb begin
          extra = '0;
          extra[47:45] = doffQ;
        end
      end
    end

    assign statNow[g] = base | extra;
    assign capAddr[g] = addrQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eccCtlQ <= '0;
      busEnQ  <= 1'b0;
    end else begin
      if (strb.wrEcc) eccCtlQ <= wrEccBits;
      if (strb.wrBus) busEnQ  <= wrBusBit;
    end
  end

  assign eccChkEn = eccCtlQ[2];
  assign irqVec[0] = (|statNow[0][63:61]) && eccCtlQ[1];
  assign irqVec[1] = (|statNow[1][63:61]) && eccCtlQ[0];
  assign irqVec[2] = (|statNow[2][63:61]) && busEnQ;

  always_comb begin
    regRdData = '0;
    case (regSel)
      3'd0:        regRdData = statNow[0];
      3'd1:        regRdData = REG_W'(capAddr[0]);
      3'd2:        regRdData = statNow[1];
      3'd3:        regRdData = REG_W'(capAddr[1]);
      3'd4:        regRdData = statNow[2];
      3'd5:        regRdData = REG_W'(capAddr[2]);
      SEL_ECC_CTL: regRdData[63:61] = eccCtlQ;
      default:     regRdData[8] = busEnQ;
    endcase
  end
endmodule

// File: rtl/errcap_top.sv
module errcap_top
  import errcap_pkg::*;
#(
  parameter int ADDR_W = 64
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtValid,
  input  logic [1:0]        evtClass,
  input  logic [1:0]        evtCause,
  input  logic [ADDR_W-1:0] evtAddr,
  input  logic [2:0]        evtSize,
  input  logic [4:0]        evtMid,
  input  logic [2:0]        evtDoff,
  input  logic [7:0]        evtSynd,
  input  logic              evtRead,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [63:0]       regWrData,
  output logic [63:0]       regRdData,
  output logic              irqUe,
  output logic              irqCe,
  output logic              irqBus
);
  strobe_t                        strb;
  logic [NUM_CLS-1:0][REG_W-1:0]  statNow;
  logic [NUM_CLS-1:0][ADDR_W-1:0] capAddr;
  logic [NUM_CLS-1:0][2:0]        primNow;
  logic [NUM_CLS-1:0]             irqVec;
  logic                           eccChkEn;
  logic                           unusedWrBits;

  assign unusedWrBits = ^{regWrData[57:9], regWrData[7:0]};

  for (genvar g = 0; g < NUM_CLS; g++) begin : gPrim
    assign primNow[g] = statNow[g][63:61];
  end

  errcap_ctrl u_ctrl (
    .evtValid (evtValid),
    .evtClass (evtClass),
    .evtCause (evtCause),
    .regWrEn  (regWrEn),
    .regSel   (regSel),
    .wrCause  (regWrData[63:58]),
    .primNow  (primNow),
    .eccChkEn (eccChkEn),
    .strb     (strb)
  );

  errcap_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .evtAddr   (evtAddr),
    .evtSize   (evtSize),
    .evtMid    (evtMid),
    .evtDoff   (evtDoff),
    .evtSynd   (evtSynd),
    .evtRead   (evtRead),
    .wrEccBits (regWrData[63:61]),
    .wrBusBit  (regWrData[8]),
    .regSel    (regSel),
    .regRdData (regRdData),
    .statNow   (statNow),
    .capAddr   (capAddr),
    .eccChkEn  (eccChkEn),
    .irqVec    (irqVec)
  );

  assign irqUe  = irqVec[0];
  assign irqCe  = irqVec[1];
  assign irqBus = irqVec[2];
endmodule

// File: rtl/errcap_check.sv
module errcap_check #(
  parameter int ADDR_W = 64
)(
  input logic                   clk,
  input logic                   rstN,
  input logic                   regWrEn,
  input logic [2:0]             regSel,
  input logic [63:0]            regRdData,
  input logic                   irqUe,
  input logic                   irqCe,
  input logic                   irqBus,
  input logic [2:0][63:0]       statNow,
  input logic [2:0][ADDR_W-1:0] capAddr
);
  for (genvar c = 0; c < 3; c++) begin : gA
    // R2: only one primary cause can be pending per class
    p_prim_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0(statNow[c][63:61]));

    // R3: captured address frozen while a primary cause is pending and not cleared
    p_addr_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      ((statNow[c][63:61] != 3'b000) && !(regWrEn && regSel == 3'(2 * c)))
      |=> $stable(capAddr[c]));

    // R3: a new secondary bit needs a primary bit pending before it
    p_sec_after_prim_r3: assert property (@(posedge clk) disable iff (!rstN)
      (|(statNow[c][60:58] & ~$past(statNow[c][60:58])))
      |-> ($past(statNow[c][63:61]) != 3'b000));
  end

  // R8: an interrupt line implies a pending primary cause in its class
  p_irq_needs_prim_r8: assert property (@(posedge clk) disable iff (!rstN)
    (irqUe || irqCe || irqBus) |->
      ((!irqUe  || statNow[0][63:61] != 3'b000) &&
       (!irqCe  || statNow[1][63:61] != 3'b000) &&
       (!irqBus || statNow[2][63:61] != 3'b000)));

  // R4: uncorrectable status has no syndrome, R10: reserved bits zero
  p_ue_reserved_r4: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd0) |-> (regRdData[57:48] == 10'd0));

  // R5: bus status has zero in 57:45 apart from the read flag
  p_bus_reserved_r5: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 3'd4) |-> (regRdData[57:48] == 10'd0 && regRdData[46:45] == 2'd0));
endmodule

bind errcap_top errcap_check #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regWrEn   (regWrEn),
  .regSel    (regSel),
  .regRdData (regRdData),
  .irqUe     (irqUe),
  .irqCe     (irqCe),
  .irqBus    (irqBus),
  .statNow   (statNow),
  .capAddr   (capAddr)
);

// File: tb/errcap_top_test.sv
module errcap_top_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evtValid = 1'b0;
  logic [1:0]  evtClass = '0, evtCause = '0;
  logic [63:0] evtAddr = '0;
  logic [2:0]  evtSize = '0, evtDoff = '0;
  logic [4:0]  evtMid = '0;
  logic [7:0]  evtSynd = '0;
  logic        evtRead = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic        irqUe, irqCe, irqBus;

  int nChk = 0;
  int nFail = 0;

  errcap_top uut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(int sel, output logic [63:0] v);
    regSel = 3'(sel);
    #1;
    v = regRdData;
  endtask

  task automatic wr(int sel, logic [63:0] d);
    @(negedge clk);
    regSel = 3'(sel); regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic drive(int cls, int cause, logic [63:0] a, logic [2:0] sz,
                       logic [4:0] mid, logic [2:0] doff, logic [7:0] syn, logic r);
    evtClass = 2'(cls); evtCause = 2'(cause); evtAddr = a; evtSize = sz;
    evtMid = mid; evtDoff = doff; evtSynd = syn; evtRead = r; evtValid = 1'b1;
  endtask

  task automatic fire(int cls, int cause, logic [63:0] a, logic [2:0] sz,
                      logic [4:0] mid, logic [2:0] doff, logic [7:0] syn, logic r);
    @(negedge clk);
    drive(cls, cause, a, sz, mid, doff, syn, r);
    @(negedge clk);
    evtValid = 1'b0;
  endtask

  function automatic logic [63:0] expStat(int cls, logic [2:0] p, logic [2:0] s,
      logic [2:0] sz, logic [4:0] mid, logic [2:0] doff, logic [7:0] syn, logic r);
    logic [63:0] v;
    v = (64'(p) << 61) | (64'(s) << 58) | (64'(sz) << 42) | (64'(mid) << 37);
    if (cls == 1) v |= 64'(syn) << 48;
    if (cls < 2) v |= 64'(doff) << 45;
    else v |= 64'(r) << 47;
    return v;
  endfunction

  function automatic logic irqOf(int cls);
    return (cls == 0) ? irqUe : (cls == 1) ? irqCe : irqBus;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    logic [63:0] v, a0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int s = 0; s < 8; s++) begin rd(s, v); chk("R1 reg", v, 64'd0); end
    chk("R1 irq", {61'd0, irqUe, irqCe, irqBus}, 64'd0);

    // R9: ECC checking off, ECC events ignored, bus recorded
    fire(0, 0, 64'hAA, 3'd1, 5'd2, 3'd3, 8'h44, 1'b0);
    rd(0, v); chk("R9 ue ignored", v, 64'd0);
    fire(1, 1, 64'hBB, 3'd1, 5'd2, 3'd3, 8'h44, 1'b0);
    rd(2, v); chk("R9 ce ignored", v, 64'd0);
    fire(2, 2, 64'hCC, 3'd5, 5'd9, 3'd3, 8'h44, 1'b1);
    rd(4, v); chk("R9 bus recorded", v, expStat(2, 3'b001, 0, 3'd5, 5'd9, 0, 0, 1'b1));
    chk("R8 bus irq off", 64'(irqBus), 64'd0);
    wr(4, {6'h3F, 58'd0});
    rd(4, v); chk("R6 bus cleared", v[63:58], 64'd0);

    // R10: control readback
    wr(6, '1); rd(6, v); chk("R10 ecc ctl", v, 64'hE000_0000_0000_0000);
    wr(7, '1); rd(7, v); chk("R10 bus ctl", v, 64'h100);

    // Sweep all classes and causes: R2 R3 R4 R5 R6 R8 R11 R12
    for (int cls = 0; cls < 3; cls++) begin
      for (int cause = 0; cause < 3; cause++) begin
        logic [63:0] a1, a2;
        logic [2:0] sz1, d1;
        logic [4:0] m1;
        logic [7:0] y1;
        logic r1;
        int c2;
        a1 = 64'h1000_0000_0000_0000 * 64'(cls + 1) + 64'(cause) * 64'h111 + 64'h40;
        a2 = ~a1;
        sz1 = 3'(cls * 3 + cause + 1);
        m1 = 5'(cls * 7 + cause * 5 + 3);
        d1 = 3'(cause * 2 + cls + 1);
        y1 = 8'h5A ^ 8'(cls * 16 + cause);
        r1 = cause[0];
        c2 = (cause + 1) % 3;
        fire(cls, cause, a1, sz1, m1, d1, y1, r1);
        rd(2 * cls, v);
        chk("R2 R4 R5 R12 primary", v, expStat(cls, 3'b100 >> cause, 0, sz1, m1, d1, y1, r1));
        rd(2 * cls + 1, v); chk("R2 address", v, a1);
        chk("R8 irq on", 64'(irqOf(cls)), 64'd1);
        for (int o = 0; o < 3; o++)
          if (o != cls) begin rd(2 * o, v); chk("R11 other class", v[63:58], 64'd0); end
        fire(cls, c2, a2, ~sz1, ~m1, ~d1, ~y1, ~r1);
        rd(2 * cls, v);
        chk("R3 secondary", v, expStat(cls, 3'b100 >> cause, 3'b100 >> c2, sz1, m1, d1, y1, r1));
        rd(2 * cls + 1, v); chk("R3 address held", v, a1);
        rd(2 * cls, v);
        wr(2 * cls, v);
        rd(2 * cls, v);
        chk("R6 writeback clears", v, expStat(cls, 0, 0, sz1, m1, d1, y1, r1));
        chk("R8 irq off after clear", 64'(irqOf(cls)), 64'd0);
      end
    end

    // R6: partial clear
    fire(0, 0, 64'h77, 3'd2, 5'd4, 3'd6, 8'h00, 1'b0);
    fire(0, 2, 64'h88, 3'd1, 5'd1, 3'd1, 8'h00, 1'b0);
    wr(0, 64'h8000_0000_0000_0000);
    rd(0, v); chk("R6 partial clear", v[63:58], 64'b000001);
    wr(0, 64'h0400_0000_0000_0000);
    rd(0, v); chk("R6 secondary clear", v[63:58], 64'd0);

    // R7: event and clear in the same cycle
    fire(1, 1, 64'h99, 3'd3, 5'd3, 3'd3, 8'h33, 1'b0);
    @(negedge clk);
    regSel = 3'd2; regWrData = 64'h4000_0000_0000_0000; regWrEn = 1'b1;
    drive(1, 2, 64'h1234, 3'd6, 5'd17, 3'd5, 8'hC3, 1'b0);
    @(negedge clk);
    regWrEn = 1'b0; evtValid = 1'b0;
    rd(2, v); chk("R7 event wins", v, expStat(1, 3'b001, 0, 3'd6, 5'd17, 3'd5, 8'hC3, 1'b0));
    rd(3, v); chk("R7 address", v, 64'h1234);

    // R10: address write ignored; R2: code 3 ignored
    rd(3, a0);
    wr(3, '1); rd(3, v); chk("R10 addr write ignored", v, a0);
    rd(0, a0);
    fire(0, 3, 64'h5, 3'd1, 5'd1, 3'd1, 8'h1, 1'b0);
    rd(0, v); chk("R2 cause 3 ignored", v, a0);
    fire(3, 0, 64'h5, 3'd1, 5'd1, 3'd1, 8'h1, 1'b0);
    rd(0, v); chk("R2 class 3 ignored", v, a0);

    // R8: enable gating on the uncorrectable class
    wr(6, 64'h8000_0000_0000_0000);
    fire(0, 1, 64'h66, 3'd1, 5'd1, 3'd1, 8'h0, 1'b0);
    rd(0, v); chk("R8 prim set", v[63:61], 64'b010);
    chk("R8 irq gated", 64'(irqUe), 64'd0);
    wr(6, 64'hC000_0000_0000_0000);
    chk("R8 irq enabled", 64'(irqUe), 64'd1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule